// File: doc/BRIEF.md
# Multi-Mode Countdown Timer with Watchdog Reset

This block is a memory-mapped 16-bit down-counter that advances at a rate set by a programmable power-of-two prescaler. The prescaler advances only in cycles where the tick-enable input is high. One counter serves four selectable behaviours when the count is exhausted: wrap-around free counting, periodic reload, a one-shot timeout that disables itself, and a watchdog. In watchdog mode an exhausted count raises a single-cycle system reset request and records the cause in a sticky flag. That flag survives the system-level soft reset and is cleared only by power-on reset.

Software programs mode and prescaler, writes the count, then sets the enable bit. In watchdog mode every later write of the load register restarts the countdown and keeps the system alive. A sticky expiry status bit tells software that any mode has run out. Software clears that bit by writing a one to it.

Top module: `cwd_timer`

## Requirements
- R1: After power-on reset (`rst`), every register reads zero and `sys_rst_req` is low.
- R2: Read data appears on `bus_rdata` the cycle after `bus_rd`. Offset 0x00 returns the last load value in bits 15:0. Offset 0x08 returns the control word: enable in bit 7, mode in bits 5:4, prescaler code in bits 3:0, and zero elsewhere, including bit 6. An unmapped offset such as 0x10 returns zero.
- R3: A write to offset 0x00 sets the running count, which reads at offset 0x04, to the written value at once, whether or not the timer is enabled.
- R4: Prescaler code n gives one count tick every 2^(n+1) enabled cycles in which `tick_en` is high. Code 15 divides by 65536. The prescaler restarts from zero on every load write and on every control write.
- R5: While control bit 7 is clear, the count does not change except by a load write.
- R6: In mode 0 (free-running), a tick at count zero wraps the count to 0xFFFF and sets the expiry status.
- R7: In mode 1 (periodic), a tick at count zero reloads the last load value and sets the expiry status.
- R8: In mode 2 (timeout), a tick at count zero leaves the count at zero, clears control bit 7 and sets the expiry status.
- R9: In mode 3 (watchdog), a tick at count zero raises `sys_rst_req` for exactly one cycle and sets the expiry status. The count then holds at zero, with no further request until the next load write.
- R10: In watchdog mode, a load write made before the count is exhausted restarts the countdown and prevents the reset request.
- R11: Status is at offset 0x0C. Bit 0 is the sticky expiry flag, cleared by writing 1 to bit 0. Bit 1 is the watchdog reset-cause flag: writes leave it unchanged, `soft_rst` leaves it unchanged, and only `rst` clears it.
- R12: `soft_rst` returns control, load, count, expiry and read data to zero.
- R13: Clearing control bit 7 before the count is exhausted suppresses the watchdog reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset; clears everything |
| soft_rst | input | 1 | Synchronous system reset; clears all state except the reset-cause flag |
| tick_en | input | 1 | Clock-enable that lets the prescaler advance this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| sys_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench drives `tick_en` as explicit bursts, so each count tick can be placed exactly. It then targets the zero boundary in each mode. A design that decrements past zero, or that reloads in the wrong mode, shows the wrong count at offset 0x04. A watchdog that keeps requesting while it sits at zero, or that ignores a keep-alive or a cleared enable, gives the wrong number of `sys_rst_req` pulses. The bench also checks that the prescaler restarts on a reload and that the code-15 divider takes exactly 65536 cycles. A cause flag that is lost on `soft_rst`, or cleared by a write, reads back wrong at offset 0x0C.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2,
    MODE_WATCHDOG = 2'd3
  } tmr_mode_e;

  localparam logic [7:0] OFS_LOAD  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_LSB = 4;
  localparam int STAT_EXP_BIT  = 0;
  localparam int STAT_WDT_BIT  = 1;
endpackage

// File: rtl/cwd_prescaler.sv
module cwd_prescaler #(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              tick_en,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int DIV_W = 1 << PSEL_W;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] term;

  // term[i] is high when the low i+1 bits are all ones: 2^(i+1) steps done
  generate
    for (genvar i = 0; i < DIV_W; i++) begin : g_term
      assign term[i] = &pcnt[i:0];
    end
  endgenerate

  logic hit;
  assign hit  = term[psel];
  assign tick = run && tick_en && hit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt <= '0;
    end else if (run && tick_en) begin
      pcnt <= hit ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/cwd_counter.sv
module cwd_counter
  import cwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt,
  output logic             oneshot_evt,
  output logic             wdt_evt,
  output logic             rst_req
);
  logic fired;
  logic at_zero;

  assign at_zero     = (count == '0);
  assign wdt_evt     = tick && at_zero && (mode == MODE_WATCHDOG) && !fired && !load_we;
  assign oneshot_evt = tick && at_zero && (mode == MODE_ONESHOT) && !load_we;
  assign expire_evt  = !load_we && tick && at_zero &&
                       ((mode != MODE_WATCHDOG) || !fired);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      count   <= '0;
      fired   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wdt_evt;
      if (load_we) begin
        count <= load_val;
        fired <= 1'b0;
      end else if (tick) begin
        if (!at_zero) begin
          count <= count - 1'b1;
        end else begin
          unique case (mode)
            MODE_FREE:     count <= '1;
            MODE_PERIODIC: count <= reload_val;
            MODE_ONESHOT:  count <= '0;
            MODE_WATCHDOG: fired <= 1'b1;
            default:       count <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cwd_regs.sv
module cwd_regs
  import cwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire_evt,
  input  logic              oneshot_evt,
  input  logic              wdt_evt,
  output logic              ctrl_en,
  output tmr_mode_e         ctrl_mode,
  output logic [PSEL_W-1:0] ctrl_psel,
  output logic [CNT_W-1:0]  load_reg,
  output logic              load_we,
  output logic              presc_clr,
  output logic              wdt_cause
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

  logic ctrl_we;
  logic stat_we;
  logic expired;
  logic wdata_unused;

  assign load_we   = bus_wr && (bus_addr == A_LOAD);
  assign ctrl_we   = bus_wr && (bus_addr == A_CTRL);
  assign stat_we   = bus_wr && (bus_addr == A_STAT);
  assign presc_clr = load_we || ctrl_we || soft_rst;
  assign wdata_unused = ^bus_wdata;

  // control and load words
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_en   <= 1'b0;
      ctrl_mode <= MODE_FREE;
      ctrl_psel <= '0;
      load_reg  <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl_en   <= bus_wdata[CTRL_EN_BIT];
        ctrl_mode <= tmr_mode_e'(bus_wdata[CTRL_MODE_LSB +: 2]);
        ctrl_psel <= bus_wdata[PSEL_W-1:0];
      end else if (oneshot_evt) begin
        ctrl_en <= 1'b0;
      end
      if (load_we) begin
        load_reg <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  // sticky expiry: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      expired <= 1'b0;
    end else if (expire_evt) begin
      expired <= 1'b1;
    end else if (stat_we && bus_wdata[STAT_EXP_BIT]) begin
      expired <= 1'b0;
    end
  end

  // reset cause: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_cause <= 1'b0;
    end else if (wdt_evt) begin
      wdt_cause <= 1'b1;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_LOAD:  rd_mux[CNT_W-1:0] = load_reg;
      A_COUNT: rd_mux[CNT_W-1:0] = count;
      A_CTRL: begin
        rd_mux[CTRL_EN_BIT]          = ctrl_en;
        rd_mux[CTRL_MODE_LSB +: 2]   = ctrl_mode;
        rd_mux[PSEL_W-1:0]           = ctrl_psel;
      end
      A_STAT: begin
        rd_mux[STAT_EXP_BIT] = expired;
        rd_mux[STAT_WDT_BIT] = wdt_cause;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cwd_timer.sv
module cwd_timer
  import cwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_req
);
  logic              ctrl_en;
  tmr_mode_e         ctrl_mode;
  logic [PSEL_W-1:0] ctrl_psel;
  logic [CNT_W-1:0]  load_reg;
  logic              load_we;
  logic              presc_clr;
  logic              wdt_cause;
  logic              tick;
  logic [CNT_W-1:0]  count;
  logic              expire_evt;
  logic              oneshot_evt;
  logic              wdt_evt;

  cwd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSEL_W(PSEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .expire_evt(expire_evt), .oneshot_evt(oneshot_evt),
    .wdt_evt(wdt_evt), .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode),
    .ctrl_psel(ctrl_psel), .load_reg(load_reg), .load_we(load_we),
    .presc_clr(presc_clr), .wdt_cause(wdt_cause)
  );

  cwd_prescaler #(.PSEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst(rst), .clr(presc_clr), .run(ctrl_en),
    .tick_en(tick_en), .psel(ctrl_psel), .tick(tick)
  );

  cwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode(ctrl_mode),
    .tick(tick), .load_we(load_we), .load_val(bus_wdata[CNT_W-1:0]),
    .reload_val(load_reg), .count(count), .expire_evt(expire_evt),
    .oneshot_evt(oneshot_evt), .wdt_evt(wdt_evt), .rst_req(sys_rst_req)
  );
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             sys_rst_req,
  input logic             run,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic             cause,
  input logic             load_we,
  input logic [CNT_W-1:0] load_val
);
  assert_req_single_R9: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);

  assert_req_origin_R9: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> ($past(run) && $past(mode) == 2'd3 && $past(count) == '0));

  assert_req_marks_cause_R11: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> cause);

  assert_cause_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    cause |=> cause);

  assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_we && !soft_rst) |=> $stable(count));

  assert_load_sets_count_R3: assert property (@(posedge clk) disable iff (rst)
    (load_we && !soft_rst) |=> (count == $past(load_val)));
endmodule

bind cwd_timer cwd_checker #(.CNT_W(CNT_W)) u_cwd_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .sys_rst_req(sys_rst_req),
  .run(ctrl_en), .mode(ctrl_mode), .count(count), .cause(wdt_cause),
  .load_we(load_we), .load_val(bus_wdata[CNT_W-1:0])
);

// File: tb/cwd_timer_bench.sv
module cwd_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;

  always #4 clk = ~clk;

  cwd_timer u_cwd_timer (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int req_pulses = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops expected read data when the design presents it
  always @(negedge clk) begin
    if (sys_rst_req) req_pulses++;
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk(input bit ok, input string t, input int got, input int e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", t, got, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sys_rst_req == 1'b0, "R1 req low", int'(sys_rst_req), 0);
    rd(8'h00, 32'h0, "R1 load");
    rd(8'h04, 32'h0, "R1 count");
    rd(8'h08, 32'h0, "R1 ctrl");
    rd(8'h0C, 32'h0, "R1 status");
    // R2 / R3 readback and immediate reload
    wr(8'h00, 32'h0001ABCD);
    rd(8'h00, 32'h0000ABCD, "R2 load readback");
    rd(8'h04, 32'h0000ABCD, "R3 count reload while disabled");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h000000BF, "R2 ctrl readback");
    wr(8'h08, 32'h0);
    rd(8'h10, 32'h0, "R2 unmapped");
    // R6 free-running wrap
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h80);
    ticks(4);
    rd(8'h04, 32'h0, "R6 reached zero");
    ticks(2);
    rd(8'h04, 32'hFFFF, "R6 wrap");
    rd(8'h0C, 32'h1, "R6 expiry set");
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h0, "R11 expiry cleared");
    wr(8'h08, 32'h0);
    // R7 periodic reload
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h90);
    ticks(8);
    rd(8'h04, 32'd3, "R7 reload");
    rd(8'h0C, 32'h1, "R7 expiry set");
    wr(8'h0C, 32'h1);
    wr(8'h08, 32'h0);
    // R8 one-shot timeout
    wr(8'h00, 32'd1);
    wr(8'h08, 32'hA0);
    ticks(4);
    rd(8'h04, 32'h0, "R8 count zero");
    rd(8'h08, 32'h20, "R8 enable cleared");
    rd(8'h0C, 32'h1, "R8 expiry set");
    wr(8'h0C, 32'h1);
    // R5 disabled counter frozen
    wr(8'h00, 32'd5);
    wr(8'h08, 32'h10);
    ticks(6);
    rd(8'h04, 32'd5, "R5 frozen");
    // R4 prescaler code 2 (divide by 8)
    wr(8'h00, 32'd4);
    wr(8'h08, 32'h92);
    ticks(8);
    rd(8'h04, 32'd3, "R4 first tick at 8");
    ticks(7);
    rd(8'h04, 32'd3, "R4 no tick at 7");
    ticks(1);
    rd(8'h04, 32'd2, "R4 tick at 8");
    // R4 prescaler restart on reload
    wr(8'h08, 32'h90);
    wr(8'h00, 32'd5);
    ticks(1);
    wr(8'h00, 32'd5);
    ticks(1);
    rd(8'h04, 32'd5, "R4 prescaler cleared by load");
    ticks(1);
    rd(8'h04, 32'd4, "R4 tick after restart");
    wr(8'h08, 32'h0);
    // R9 / R10 watchdog with keep-alive
    req_pulses = 0;
    wr(8'h00, 32'd2);
    wr(8'h08, 32'hB0);
    ticks(4);
    rd(8'h04, 32'h0, "R10 at zero before kick");
    wr(8'h00, 32'd2);
    rd(8'h04, 32'd2, "R10 kick reloads");
    ticks(4);
    chk(req_pulses == 0, "R10 no request after kick", req_pulses, 0);
    ticks(2);
    repeat (2) @(negedge clk);
    chk(req_pulses == 1, "R9 one request", req_pulses, 1);
    rd(8'h0C, 32'h3, "R9 expiry and cause");
    ticks(6);
    chk(req_pulses == 1, "R9 no repeat at zero", req_pulses, 1);
    rd(8'h04, 32'h0, "R9 holds zero");
    // R12 soft reset; R11 cause survives
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(8'h08, 32'h0, "R12 ctrl cleared");
    rd(8'h00, 32'h0, "R12 load cleared");
    rd(8'h04, 32'h0, "R12 count cleared");
    rd(8'h0C, 32'h2, "R11 cause survives soft reset");
    wr(8'h0C, 32'h3);
    rd(8'h0C, 32'h2, "R11 cause ignores write");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h0C, 32'h0, "R11 cause cleared by power-on reset");
    // R13 disable before expiry
    req_pulses = 0;
    wr(8'h00, 32'd1);
    wr(8'h08, 32'hB0);
    ticks(2);
    wr(8'h08, 32'h30);
    ticks(10);
    repeat (2) @(negedge clk);
    chk(req_pulses == 0, "R13 no request when disabled", req_pulses, 0);
    rd(8'h0C, 32'h0, "R13 no cause");
    // R4 largest divider
    wr(8'h08, 32'h9F);
    wr(8'h00, 32'd2);
    ticks(65535);
    rd(8'h04, 32'd2, "R4 no tick before 65536");
    ticks(1);
    rd(8'h04, 32'd1, "R4 tick at 65536");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule